// File: doc/BRIEF.md
# Programmable I2C SCL Timing Generator

This block produces the clock line of an I2C controller. It drives SCL low for a programmed number of count ticks, then lets it go. It starts timing the high phase only once the SCL input is seen high after synchronization. Slave clock stretching and slow rise time therefore lengthen the bus period without shortening the high phase. Each of the two counts is nine bits wide. A separate input carries bit 8. A build parameter can drop that bit, which caps both counts at 255. The count tick is the block clock, or the block clock divided by two.

A byte controller drives `run` to start clocking and watches the strobes. `fall_stb` marks the first cycle SCL is driven low, where SDA may change. `rise_stb` marks the first cycle after SCL is confirmed high, where SDA is sampled. When `run` rises, the block first times the START hold interval with the high count, then begins the first low phase. When `stop_req` is present at the end of a low phase, it times the STOP setup interval with the high count and then stays released. `hold` freezes SCL low at the end of a low phase.

The state machine has these states:
- `ST_IDLE`: SCL released.
- `ST_START_HOLD`: released, counting the high count.
- `ST_LOW`: driving low, counting the low count.
- `ST_LOW_HOLD`: driving low, frozen by `hold`.
- `ST_RISE_WAIT`: released, waiting for SCL to be sensed high.
- `ST_HIGH`: released, counting the high count.
- `ST_STOP_WAIT`: released, waiting for SCL to be sensed high.
- `ST_STOP_SETUP`: released, counting the high count.
- `ST_DONE`: released until `run` drops.

The transitions are:
- IDLE→START_HOLD when `run` is high.
- START_HOLD→LOW after the high count.
- LOW→LOW_HOLD, STOP_WAIT or RISE_WAIT after the low count, once SCL has been seen low.
- LOW_HOLD→STOP_WAIT or RISE_WAIT when `hold` drops.
- RISE_WAIT→HIGH and STOP_WAIT→STOP_SETUP on sensed high.
- HIGH→LOW after the high count.
- STOP_SETUP→DONE after the high count.
- Any state goes to IDLE when `run` is low.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and while `run` is low, `scl_oe` is 0 and all four strobes are 0.
- R2: After `run` rises, SCL stays released while the START hold interval is timed. That interval is max(H,1) ticks, and a tick counts only while the synchronized SCL is high. Then `scl_oe` goes to 1, with `fall_stb` and `start_done_stb` high together in that first driven cycle.
- R3: A low phase keeps `scl_oe` at 1 for max(L,1) ticks, counted from the first driven cycle. The phase is extended only until SCL has been sensed low through the synchronizer.
- R4: The high phase starts counting only after the SCL input has been seen high through SYNC_STAGES flops. With a tick every cycle, `fall_stb` follows `rise_stb` by exactly max(H,1) cycles, however long the line was held low by a slave.
- R5: `fall_stb` is a one-cycle pulse in the first cycle of `scl_oe`=1. `rise_stb` is a one-cycle pulse in the first released cycle after SCL is confirmed high. The two are never high together.
- R6: With EXT_EN=1, L = 256·`low_ext` + `low_count` and H = 256·`high_ext` + `high_count`. With EXT_EN=0, the ext inputs are ignored.
- R7: With `div2_sel`=0 every clock is a tick. With `div2_sel`=1 every second clock is a tick. The first tick falls on the second cycle that `run` is high, so a low phase of L ticks lasts 2L-1 or 2L cycles.
- R8: A count of zero acts as one tick.
- R9: If `hold` is 1 when a low phase ends, `scl_oe` stays 1 until `hold` is 0. The block then proceeds as at a normal low-phase end.
- R10: If `stop_req` is 1 when a low phase ends, SCL is released. Once SCL is sensed high, max(H,1) ticks are timed and `stop_done_stb` pulses. After that, `scl_oe` and `fall_stb` stay 0 until `run` drops.
- R11: One cycle after `run` is sampled low, `scl_oe` is 0. The next rise of `run` starts again with the START hold interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Clocking request; low releases SCL and resets timing |
| stop_req | input | 1 | Time STOP setup at the end of the current low phase |
| hold | input | 1 | Freeze SCL low at the end of a low phase |
| div2_sel | input | 1 | 1 = tick on every second clock |
| low_count | input | BASE_W | Low phase count, lower bits |
| low_ext | input | 1 | Low phase count, bit 8 |
| high_count | input | BASE_W | High phase / START hold / STOP setup count, lower bits |
| high_ext | input | 1 | High count, bit 8 |
| scl_in | input | 1 | Sensed SCL level |
| scl_oe | output | 1 | 1 = pull SCL low |
| fall_stb | output | 1 | First cycle SCL is driven low |
| rise_stb | output | 1 | First cycle after SCL confirmed high |
| start_done_stb | output | 1 | START hold interval complete |
| stop_done_stb | output | 1 | STOP setup interval complete |

## Verification
The bench holds SCL low with a modelled slave. A design that started the high count at release would then cut the rise-to-fall distance short. Very short low phases are run through the synchronizer delay. A design that trusted a stale high sample would skip the low phase entirely. The ninth count bit is exercised on two instances, one built with the bit and one without; a mix-up of the bit would show up as a 6-cycle versus 262-cycle difference. The tests also cover zero counts, the divide-by-two phase of the tick, hold, stop and a drop of `run` in mid-phase. A design that miscounted any of these would run the phase for a different length or go on clocking after the stop.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START_HOLD,
        ST_LOW,
        ST_LOW_HOLD,
        ST_RISE_WAIT,
        ST_HIGH,
        ST_STOP_WAIT,
        ST_STOP_SETUP,
        ST_DONE
    } sclg_state_e;

endpackage

// File: rtl/scl_tick_div.sv
module scl_tick_div (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic div2_sel,
    output logic tick
);
    logic phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= run ? ~phase_q : 1'b0;
        end
    end

    assign tick = run & (~div2_sel | phase_q);
endmodule

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= d;
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/scl_count_sel.sv
module scl_count_sel #(
    parameter int BASE_W = 8,
    parameter bit EXT_EN = 1'b1,
    localparam int CW = BASE_W + 1
) (
    input  logic [BASE_W-1:0] base,
    input  logic              ext,
    output logic [CW-1:0]     eff
);
    logic [CW-1:0] raw;

    generate
        if (EXT_EN) begin : g_ext
            assign raw = {ext, base};
        end else begin : g_noext
            logic unused_ext;
            assign unused_ext = ext;
            assign raw = {1'b0, base};
        end
    endgenerate

    assign eff = (raw == '0) ? CW'(1) : raw;
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int BASE_W      = 8,
    parameter bit EXT_EN      = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              stop_req,
    input  logic              hold,
    input  logic              div2_sel,
    input  logic [BASE_W-1:0] low_count,
    input  logic              low_ext,
    input  logic [BASE_W-1:0] high_count,
    input  logic              high_ext,
    input  logic              scl_in,
    output logic              scl_oe,
    output logic              fall_stb,
    output logic              rise_stb,
    output logic              start_done_stb,
    output logic              stop_done_stb
);
    localparam int CW = BASE_W + 1;

    logic          tick;
    logic          scl_s;
    logic [CW-1:0] lo_eff;
    logic [CW-1:0] hi_eff;

    sclg_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          seen_lo_q, seen_lo_d;
    logic          drive_d, fall_d, rise_d, sdone_d, pdone_d;

    scl_tick_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .div2_sel (div2_sel),
        .tick     (tick)
    );

    scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (scl_in),
        .q     (scl_s)
    );

    scl_count_sel #(.BASE_W(BASE_W), .EXT_EN(EXT_EN)) u_lo_sel (
        .base (low_count),
        .ext  (low_ext),
        .eff  (lo_eff)
    );

    scl_count_sel #(.BASE_W(BASE_W), .EXT_EN(EXT_EN)) u_hi_sel (
        .base (high_count),
        .ext  (high_ext),
        .eff  (hi_eff)
    );

    logic lo_reached, hi_reached, lo_ok;
    assign lo_reached = (cnt_q >= lo_eff - CW'(1));
    assign hi_reached = (cnt_q >= hi_eff - CW'(1));
    assign lo_ok      = seen_lo_q | ~scl_s;

    // next-state process
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        seen_lo_d = seen_lo_q;
        if (!run) begin
            state_d   = ST_IDLE;
            cnt_d     = '0;
            seen_lo_d = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_START_HOLD;
                    cnt_d   = '0;
                end
                ST_START_HOLD: begin
                    if (tick && scl_s) begin
                        if (hi_reached) begin
                            state_d   = ST_LOW;
                            cnt_d     = '0;
                            seen_lo_d = 1'b0;
                        end else begin
                            cnt_d = cnt_q + CW'(1);
                        end
                    end
                end
                ST_LOW: begin
                    seen_lo_d = lo_ok;
                    if (tick) begin
                        if (lo_reached) begin
                            if (lo_ok) begin
                                cnt_d = '0;
                                if (hold)          state_d = ST_LOW_HOLD;
                                else if (stop_req) state_d = ST_STOP_WAIT;
                                else               state_d = ST_RISE_WAIT;
                            end
                        end else begin
                            cnt_d = cnt_q + CW'(1);
                        end
                    end
                end
                ST_LOW_HOLD: begin
                    if (!hold) state_d = stop_req ? ST_STOP_WAIT : ST_RISE_WAIT;
                end
                ST_RISE_WAIT: begin
                    if (scl_s) begin
                        state_d = ST_HIGH;
                        cnt_d   = '0;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        if (hi_reached) begin
                            state_d   = ST_LOW;
                            cnt_d     = '0;
                            seen_lo_d = 1'b0;
                        end else begin
                            cnt_d = cnt_q + CW'(1);
                        end
                    end
                end
                ST_STOP_WAIT: begin
                    if (scl_s) begin
                        state_d = ST_STOP_SETUP;
                        cnt_d   = '0;
                    end
                end
                ST_STOP_SETUP: begin
                    if (tick) begin
                        if (hi_reached) state_d = ST_DONE;
                        else            cnt_d   = cnt_q + CW'(1);
                    end
                end
                ST_DONE: begin
                    state_d = ST_DONE;
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // output process: decode the transition being taken
    always_comb begin
        drive_d = (state_d == ST_LOW) || (state_d == ST_LOW_HOLD);
        fall_d  = (state_d == ST_LOW) &&
                  ((state_q == ST_START_HOLD) || (state_q == ST_HIGH));
        rise_d  = ((state_q == ST_RISE_WAIT) && (state_d == ST_HIGH)) ||
                  ((state_q == ST_STOP_WAIT) && (state_d == ST_STOP_SETUP));
        sdone_d = (state_q == ST_START_HOLD) && (state_d == ST_LOW);
        pdone_d = (state_q == ST_STOP_SETUP) && (state_d == ST_DONE);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q        <= ST_IDLE;
            cnt_q          <= '0;
            seen_lo_q      <= 1'b0;
            scl_oe         <= 1'b0;
            fall_stb       <= 1'b0;
            rise_stb       <= 1'b0;
            start_done_stb <= 1'b0;
            stop_done_stb  <= 1'b0;
        end else begin
            state_q        <= state_d;
            cnt_q          <= cnt_d;
            seen_lo_q      <= seen_lo_d;
            scl_oe         <= drive_d;
            fall_stb       <= fall_d;
            rise_stb       <= rise_d;
            start_done_stb <= sdone_d;
            stop_done_stb  <= pdone_d;
        end
    end
endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic hold,
    input logic scl_s,
    input logic scl_oe,
    input logic fall_stb,
    input logic rise_stb,
    input logic start_done_stb,
    input logic stop_done_stb
);
    logic stopped_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             stopped_q <= 1'b0;
        else if (!run)          stopped_q <= 1'b0;
        else if (stop_done_stb) stopped_q <= 1'b1;
    end

    assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !scl_oe);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !(fall_stb || rise_stb || start_done_stb || stop_done_stb));

    assert_fall_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> (scl_oe && !$past(scl_oe)));

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fall_stb, rise_stb}));

    assert_rise_sensed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (!scl_oe && $past(scl_s)));

    assert_start_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_done_stb |-> fall_stb);

    assert_hold_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hold && scl_oe) |=> scl_oe);

    assert_stop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stopped_q |-> (!scl_oe && !fall_stb));
endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .run            (run),
    .hold           (hold),
    .scl_s          (scl_s),
    .scl_oe         (scl_oe),
    .fall_stb       (fall_stb),
    .rise_stb       (rise_stb),
    .start_done_stb (start_done_stb),
    .stop_done_stb  (stop_done_stb)
);

// File: tb/scl_timing_gen_test.sv
`timescale 1ns/1ps

module scl_timing_ref #(
    parameter bit EXT_EN = 1'b1,
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       stop_req,
    input  logic       hold,
    input  logic       div2_sel,
    input  logic [7:0] low_count,
    input  logic       low_ext,
    input  logic [7:0] high_count,
    input  logic       high_ext,
    input  logic       scl_in,
    output logic       m_oe,
    output logic       m_fall,
    output logic       m_rise,
    output logic       m_sdone,
    output logic       m_pdone
);
    // phase codes: 0 idle, 1 start hold, 2 low, 3 frozen low, 4 await rise,
    // 5 high, 6 await rise before stop, 7 stop setup, 8 finished
    int  ph, rem, lo, hi;
    bit  pre, seen, tk, s, ok;
    bit  sq[$];

    function automatic int eff(input bit e, input logic [7:0] b);
        int v;
        v = (EXT_EN ? 256 * int'(e) : 0) + int'(b);
        return (v == 0) ? 1 : v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph = 0; rem = 0; pre = 0; seen = 0;
            sq.delete();
            for (int i = 0; i < STAGES; i++) sq.push_back(1'b1);
            m_oe = 0; m_fall = 0; m_rise = 0; m_sdone = 0; m_pdone = 0;
        end else begin
            s = sq[0];
            void'(sq.pop_front());
            sq.push_back(scl_in);
            tk  = run && (!div2_sel || pre);
            pre = run ? !pre : 1'b0;
            lo  = eff(low_ext, low_count);
            hi  = eff(high_ext, high_count);
            m_fall = 0; m_rise = 0; m_sdone = 0; m_pdone = 0;
            if (!run) begin
                ph = 0; seen = 0;
            end else begin
                case (ph)
                    0: begin ph = 1; rem = hi; end
                    1: if (tk && s) begin
                        if (rem <= 1) begin
                            ph = 2; rem = lo; seen = 0; m_fall = 1; m_sdone = 1;
                        end else rem--;
                    end
                    2: begin
                        ok = seen || !s;
                        seen = ok;
                        if (tk) begin
                            if (rem <= 1) begin
                                if (ok) ph = hold ? 3 : (stop_req ? 6 : 4);
                            end else rem--;
                        end
                    end
                    3: if (!hold) ph = stop_req ? 6 : 4;
                    4: if (s) begin ph = 5; rem = hi; m_rise = 1; end
                    5: if (tk) begin
                        if (rem <= 1) begin
                            ph = 2; rem = lo; seen = 0; m_fall = 1;
                        end else rem--;
                    end
                    6: if (s) begin ph = 7; rem = hi; m_rise = 1; end
                    7: if (tk) begin
                        if (rem <= 1) begin ph = 8; m_pdone = 1; end
                        else rem--;
                    end
                    default: ph = 8;
                endcase
            end
            m_oe = (ph == 2) || (ph == 3);
        end
    end
endmodule

module scl_timing_gen_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n, run, stop_req, hold, div2_sel, low_ext, high_ext;
    logic [7:0] low_count, high_count;
    logic       scl_in, stretch;
    logic       oe_a, fall_a, rise_a, sd_a, pd_a;
    logic       oe_b, fall_b, rise_b, sd_b, pd_b;
    logic       r_oe_a, r_fall_a, r_rise_a, r_sd_a, r_pd_a;
    logic       r_oe_b, r_fall_b, r_rise_b, r_sd_b, r_pd_b;
    int         checks = 0;
    int         errors = 0;
    bit         ended  = 0;

    scl_timing_gen #(.BASE_W(8), .EXT_EN(1'b1), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .run(run), .stop_req(stop_req), .hold(hold),
        .div2_sel(div2_sel), .low_count(low_count), .low_ext(low_ext),
        .high_count(high_count), .high_ext(high_ext), .scl_in(scl_in),
        .scl_oe(oe_a), .fall_stb(fall_a), .rise_stb(rise_a),
        .start_done_stb(sd_a), .stop_done_stb(pd_a));

    scl_timing_gen #(.BASE_W(8), .EXT_EN(1'b0), .SYNC_STAGES(2)) uut8 (
        .clk(clk), .rst_n(rst_n), .run(run), .stop_req(stop_req), .hold(hold),
        .div2_sel(div2_sel), .low_count(low_count), .low_ext(low_ext),
        .high_count(high_count), .high_ext(high_ext), .scl_in(scl_in),
        .scl_oe(oe_b), .fall_stb(fall_b), .rise_stb(rise_b),
        .start_done_stb(sd_b), .stop_done_stb(pd_b));

    scl_timing_ref #(.EXT_EN(1'b1), .STAGES(2)) ref_a (
        .clk(clk), .rst_n(rst_n), .run(run), .stop_req(stop_req), .hold(hold),
        .div2_sel(div2_sel), .low_count(low_count), .low_ext(low_ext),
        .high_count(high_count), .high_ext(high_ext), .scl_in(scl_in),
        .m_oe(r_oe_a), .m_fall(r_fall_a), .m_rise(r_rise_a),
        .m_sdone(r_sd_a), .m_pdone(r_pd_a));

    scl_timing_ref #(.EXT_EN(1'b0), .STAGES(2)) ref_b (
        .clk(clk), .rst_n(rst_n), .run(run), .stop_req(stop_req), .hold(hold),
        .div2_sel(div2_sel), .low_count(low_count), .low_ext(low_ext),
        .high_count(high_count), .high_ext(high_ext), .scl_in(scl_in),
        .m_oe(r_oe_b), .m_fall(r_fall_b), .m_rise(r_rise_b),
        .m_sdone(r_sd_b), .m_pdone(r_pd_b));

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // open-drain bus: low if anyone pulls, rises two cycles after release
    initial begin
        int rc;
        rc = 0;
        scl_in = 1'b1;
        forever begin
            @(negedge clk);
            if (oe_a || oe_b || stretch) begin
                scl_in = 1'b0;
                rc = 0;
            end else if (rc < 2) begin
                rc++;
            end else begin
                scl_in = 1'b1;
            end
        end
    end

    // cycle-by-cycle comparison against the reference model
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            chk_eq("R3", "scl_oe A",        int'(oe_a),   int'(r_oe_a));
            chk_eq("R5", "fall_stb A",      int'(fall_a), int'(r_fall_a));
            chk_eq("R4", "rise_stb A",      int'(rise_a), int'(r_rise_a));
            chk_eq("R2", "start_done A",    int'(sd_a),   int'(r_sd_a));
            chk_eq("R10", "stop_done A",    int'(pd_a),   int'(r_pd_a));
            chk_eq("R6", "scl_oe B",        int'(oe_b),   int'(r_oe_b));
            chk_eq("R5", "fall_stb B",      int'(fall_b), int'(r_fall_b));
            chk_eq("R4", "rise_stb B",      int'(rise_b), int'(r_rise_b));
            chk_eq("R2", "start_done B",    int'(sd_b),   int'(r_sd_b));
            chk_eq("R10", "stop_done B",    int'(pd_b),   int'(r_pd_b));
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    function automatic bit sig(input int sel);
        case (sel)
            0: return fall_a;
            1: return rise_a;
            2: return pd_a;
            3: return sd_a;
            default: return 1'b0;
        endcase
    endfunction

    task automatic wait_sig(input int sel, output bit got);
        got = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (sig(sel)) begin
                got = 1;
                return;
            end
        end
    endtask

    task automatic rise_to_fall(output int n);
        n = 0;
        while (!fall_a && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic low_width(output int w);
        w = 0;
        while (oe_a && w < 5000) begin
            w++;
            @(negedge clk);
        end
    endtask

    task automatic restart();
        run = 0;
        repeat (4) @(negedge clk);
        run = 1;
    endtask

    initial begin
        bit got;
        int w, n, wa, wb, bad;
        rst_n = 0; run = 0; stop_req = 0; hold = 0; div2_sel = 0; stretch = 0;
        low_count = 8'd6; low_ext = 0; high_count = 8'd4; high_ext = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        // R1: idle after reset
        chk_eq("R1", "scl_oe idle A", int'(oe_a), 0);
        chk_eq("R1", "scl_oe idle B", int'(oe_b), 0);
        chk_eq("R1", "strobes idle", int'({fall_a, rise_a, sd_a, pd_a}), 0);

        // R2 / R3 / R4: tick every cycle, L=6, H=4
        run = 1;
        wait_sig(3, got);
        chk_eq("R2", "start hold completed", int'(got), 1);
        chk_eq("R2", "fall with start_done", int'(fall_a), 1);
        low_width(w);
        chk_eq("R3", "low width L=6", w, 6);
        wait_sig(1, got);
        rise_to_fall(n);
        chk_eq("R4", "rise to fall H=4", n, 4);

        // R8: zero high count acts as one tick
        restart();
        high_count = 8'd0;
        wait_sig(1, got);
        rise_to_fall(n);
        chk_eq("R8", "rise to fall H=0", n, 1);

        // R6: ninth bit used by A, ignored by B
        run = 0;
        low_count = 8'd6; low_ext = 1; high_count = 8'd3;
        restart();
        wait_sig(3, got);
        wa = 0; wb = 0;
        while ((oe_a || oe_b) && wa < 5000) begin
            if (oe_a) wa++;
            if (oe_b) wb++;
            @(negedge clk);
        end
        chk_eq("R6", "low width with ext bit", wa, 262);
        chk_eq("R6", "low width ext ignored", wb, 6);

        // R7: divide by two
        run = 0;
        low_ext = 0; low_count = 8'd5; div2_sel = 1;
        restart();
        wait_sig(3, got);
        low_width(w);
        chk_eq("R7", "div2 low width in 9..10", int'(w == 9 || w == 10), 1);
        wait_sig(1, got);
        rise_to_fall(n);
        chk_eq("R7", "div2 high in 5..6", int'(n == 5 || n == 6), 1);

        // R9: hold freezes low
        run = 0; div2_sel = 0;
        restart();
        wait_sig(3, got);
        hold = 1;
        repeat (40) @(negedge clk);
        chk_eq("R9", "scl_oe frozen by hold", int'(oe_a), 1);
        hold = 0;
        wait_sig(1, got);
        chk_eq("R9", "rise after hold release", int'(got), 1);

        // R4: slave stretching does not eat the high phase
        wait_sig(0, got);
        stretch = 1;
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (rise_a) bad++;
        end
        chk_eq("R4", "no rise while stretched", bad, 0);
        stretch = 0;
        wait_sig(1, got);
        rise_to_fall(n);
        chk_eq("R4", "rise to fall after stretch", n, 3);

        // R10: stop setup then quiet
        stop_req = 1;
        wait_sig(2, got);
        chk_eq("R10", "stop setup completed", int'(got), 1);
        stop_req = 0;
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (oe_a || fall_a) bad++;
        end
        chk_eq("R10", "quiet after stop", bad, 0);

        // R11: run drop in mid low phase, then restart
        restart();
        wait_sig(3, got);
        @(negedge clk);
        run = 0;
        @(negedge clk);
        chk_eq("R11", "released after run drop", int'(oe_a), 0);
        run = 1;
        wait_sig(3, got);
        chk_eq("R11", "start hold again", int'(got), 1);

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule